// File: doc/BRIEF.md
# Error code beep sequencer

This block plays an 8-bit fatal error code as a series of short beeps, so that a fault can be read by ear when no display is available. A one-cycle `start_i` pulse captures `code_i`. The code is split into four 2-bit groups, and each group is played as a burst of one to four equal beeps. Beeps in the same group are separated by a short silence. Each group is followed by a longer silence.

While a beep is sounding, `spk_o` carries a square tone derived from the clock. At all other times it is held low. `busy_o` covers the whole sequence. `done_o` pulses once when the sequence ends. All durations are parameters given in clock cycles: beep length `ON_CYC`, silence inside a group `OFF_CYC`, silence after a group `GRP_GAP_CYC`, and tone half-period `TONE_DIV`.

Top module: `beep_seq`

## Requirements
- R1: The groups play in order from bits 7:6, then 5:4, then 3:2, and last 1:0.
- R2: A group plays a number of beeps equal to its 2-bit value plus one. For example, code 16h plays 1, 2, 2 and 3 beeps, and code 16h keeps `busy_o` high for 8·ON_CYC + 4·OFF_CYC + 4·GRP_GAP_CYC cycles.
- R3: Each beep lasts exactly ON_CYC cycles. During a beep, `spk_o` is high for the first TONE_DIV cycles and then inverts every TONE_DIV cycles.
- R4: `spk_o` is low at every cycle outside a beep.
- R5: Two beeps of the same group are separated by exactly OFF_CYC silent cycles. Every group, including the last one, is followed by exactly GRP_GAP_CYC silent cycles.
- R6: A start is accepted when `start_i` is high at a clock edge while `busy_o` is low. `busy_o` rises in the cycle after that edge and stays high through the last silence of the sequence.
- R7: A start pulse given while `busy_o` is high is ignored. The running sequence keeps its code and its timing.
- R8: `done_o` is high for exactly one cycle, the cycle right after the final silence, and `busy_o` is low in that cycle. A start given in that cycle is accepted.
- R9: While `rst_ni` is low, and right after it, `spk_o`, `busy_o` and `done_o` are low. A reset in the middle of a sequence ends that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a sequence when the block is idle |
| code_i | input | 8 | Error code, captured when a start is accepted |
| spk_o | output | 1 | Speaker enable, carrying the gated tone |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The hardest situations to reach from the ports are the ends of a sequence. The first is a start that lands exactly in the `done_o` cycle, which must be accepted. The second is a start that lands in the last cycle of the final silence, which must be ignored. The stimulus reaches both by waiting on `done_o`, or by holding `start_i` high through an entire sequence so that every cycle boundary sees a request. A cycle-by-cycle reference model then shows any sequence that is launched early or late.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_OFF  = 2'd2,
    ST_GAP  = 2'd3
  } beep_state_e;
endpackage

// File: rtl/beep_tick_cnt.sv
module beep_tick_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/beep_tone.sv
module beep_tone #(
  parameter int TONE_DIV = 2,
  localparam int TD_W = $clog2(TONE_DIV) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tone_o
);
  localparam logic [TD_W-1:0] DIV_LAST = TD_W'(TONE_DIV - 1);

  logic [TD_W-1:0] div_q;
  logic            ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // high for the first half-period of every beep
  assign tone_o = en_i & ~ph_q;
endmodule

// File: rtl/beep_seq.sv
module beep_seq
  import beep_pkg::*;
#(
  parameter int NUM_GRP     = 4,
  parameter int GRP_W       = 2,
  parameter int ON_CYC      = 8,
  parameter int OFF_CYC     = 4,
  parameter int GRP_GAP_CYC = 12,
  parameter int TONE_DIV    = 2,
  localparam int CODE_W     = NUM_GRP * GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              spk_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_CYC = (ON_CYC > OFF_CYC) ?
                           ((ON_CYC > GRP_GAP_CYC) ? ON_CYC : GRP_GAP_CYC) :
                           ((OFF_CYC > GRP_GAP_CYC) ? OFF_CYC : GRP_GAP_CYC);
  localparam int CNT_W = $clog2(MAX_CYC) + 1;
  localparam int IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GRP_GAP_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_GRP = IDX_W'(NUM_GRP - 1);

  beep_state_e       state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;   // current group sits in the top bits
  logic [GRP_W-1:0]  rem_q, rem_d;     // beeps left after the current one
  logic [IDX_W-1:0]  grp_q, grp_d;
  logic              done_q, done_d;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              tmr_zero;

  beep_tick_cnt #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  beep_tone #(.TONE_DIV(TONE_DIV)) u_tone (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_ON),
    .tone_o (spk_o)
  );

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    rem_d    = rem_q;
    grp_d    = grp_q;
    done_d   = 1'b0;
    load     = 1'b0;
    load_val = ON_LD;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        code_d  = code_i;
        rem_d   = code_i[CODE_W-1 -: GRP_W];
        grp_d   = '0;
        state_d = ST_ON;
        load    = 1'b1;
      end
      ST_ON: if (tmr_zero) begin
        load = 1'b1;
        if (rem_q != '0) begin
          rem_d    = rem_q - 1'b1;
          state_d  = ST_OFF;
          load_val = OFF_LD;
        end else begin
          state_d  = ST_GAP;
          load_val = GAP_LD;
        end
      end
      ST_OFF: if (tmr_zero) begin
        state_d = ST_ON;
        load    = 1'b1;
      end
      ST_GAP: if (tmr_zero) begin
        if (grp_q == LAST_GRP) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          grp_d   = grp_q + 1'b1;
          code_d  = code_q << GRP_W;
          rem_d   = code_q[CODE_W-GRP_W-1 -: GRP_W];
          state_d = ST_ON;
          load    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      rem_q   <= '0;
      grp_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      rem_q   <= rem_d;
      grp_q   <= grp_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/beep_seq_chk.sv
module beep_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic spk_o,
  input logic busy_o,
  input logic done_o
);
  assert_spk_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_o |-> busy_o);

  assert_busy_on_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_busy_end_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_no_spk_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !spk_o);
endmodule

bind beep_seq beep_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .spk_o   (spk_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/beep_seq_test.sv
module beep_seq_test;
  localparam int ON_CYC = 8, OFF_CYC = 4, GAP_CYC = 12, TDIV = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] code = '0;
  logic spk, busy, done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string req = "R9";
  logic [2:0] exp_q[$];          // {busy, spk, done} for coming cycles
  logic [2:0] cur = '0;

  always #2 clk = ~clk;

  beep_seq #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC), .GRP_GAP_CYC(GAP_CYC),
             .TONE_DIV(TDIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code),
    .spk_o(spk), .busy_o(busy), .done_o(done));

  // reference model: expands a code into its per-cycle output list
  task automatic build(input logic [7:0] c);
    for (int g = 0; g < 4; g++) begin
      int n;
      n = ((c >> (6 - 2 * g)) & 8'h3) + 1;
      for (int b = 0; b < n; b++) begin
        for (int k = 0; k < ON_CYC; k++)
          exp_q.push_back({1'b1, ((k / TDIV) % 2) == 0, 1'b0});
        for (int k = 0; k < ((b < n - 1) ? OFF_CYC : GAP_CYC); k++)
          exp_q.push_back(3'b100);
      end
    end
    exp_q.push_back(3'b001);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      cur <= '0;
    end else begin
      if (exp_q.size() == 0 && start) build(code);
      if (exp_q.size() != 0) cur <= exp_q.pop_front();
      else cur <= '0;
    end
  end

  task automatic check(input string r, input logic act, input logic expv, input string nm);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", r, nm, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({req, cur[1] ? "/R3" : "/R4"}, spk, cur[1], "spk_o");
      check({req, "/R6"}, busy, cur[2], "busy_o");
      check({req, "/R8"}, done, cur[0], "done_o");
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pulse(input logic [7:0] c);
    @(negedge clk); code = c; start = 1'b1;
    @(negedge clk); start = 1'b0; code = 8'hAA;
  endtask

  task automatic run(input logic [7:0] c, output int busy_len);
    busy_len = 0;
    pulse(c);
    while (!done) begin
      @(negedge clk);
      if (busy) busy_len++;
    end
    busy_len++;  // cycle sampled at the start edge's following negedge
  endtask

  initial begin
    int len;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", spk, 1'b0, "spk_o"); check("R9", busy, 1'b0, "busy_o");
    check("R9", done, 1'b0, "done_o");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    req = "R2";  // 16h -> 1-2-2-3
    run(8'h16, len);
    check("R2", len == 8*ON_CYC + 4*OFF_CYC + 4*GAP_CYC, 1'b1, "busy length");
    req = "R5"; run(8'h00, len); run(8'hFF, len);
    req = "R1"; run(8'hC0, len); run(8'h03, len); run(8'h1B, len);

    req = "R7";  // extra starts mid-sequence, other code
    pulse(8'h40);
    repeat (20) @(negedge clk);
    code = 8'hFF; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    pulse(8'h01);
    while (!done) @(negedge clk);

    req = "R8";  // start held high: restart in the done cycle
    @(negedge clk); code = 8'h21; start = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);

    req = "R9";  // reset mid-sequence
    pulse(8'hE4);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", spk, 1'b0, "spk_o"); check("R9", busy, 1'b0, "busy_o");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    req = "R3"; run(8'h9C, len);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule